// File: doc/BRIEF.md
# ADC serial result shifter

This block is the digital output side of a 16-bit sampling converter's serial port. A stub core stands in for the analog conversion. That stub is a down-counter that holds the active-low busy flag for a fixed number of system clocks. When busy returns high, the stub latches the conversion word from its input. A chip-select and a read/convert line start a conversion and open a read.

All logic runs on one system clock. Each rising edge of the external data clock arrives as a one-cycle tick, so the data clock may be continuous or gapped. A read frame begins with a one-tick framing pulse. The result then follows most significant bit first, one bit per tick. After the last bit, the block forwards the bits it sampled on a chain input, sixteen ticks late, so several converters can share one serial line in a daisy chain.

The block has two read modes. In read-after mode, a read waits for the conversion to finish. In read-during mode, chip-select is held low, and each conversion start also starts a frame that carries the previous result.

Top module: `adcsr_serial_out`

## Requirements
- R1: After reset, the sync output and the data output are 0 and the busy flag `busy_n_o` is 1.
- R2: A conversion starts when chip-select falls while read/convert is low, or when read/convert falls while chip-select is low. `busy_n_o` then reads 0 for exactly CONV_CYCLES system clocks.
- R3: A start condition seen while `busy_n_o` is 0 is ignored and does not lengthen the busy period.
- R4: The result register takes the conversion word only when `busy_n_o` returns to 1. A read made during a conversion therefore returns the previous word.
- R5: In read-after mode (`mode_i`=0), a frame is armed while chip-select is low, read/convert is high and `busy_n_o` is 1. On the first tick of the armed frame, sync goes to 1 and data stays 0. Sync lasts exactly one tick.
- R6: On the next tick, sync returns to 0 and data carries result bit W-1. Each later tick carries the next lower bit, so bit 0 appears on tick W+1 of the frame, counting the sync tick as tick 1.
- R7: The chain input is sampled on each tick from frame tick 2 onward. From tick W+2 on, data repeats the value sampled W ticks earlier, one bit per tick.
- R8: In read-during mode (`mode_i`=1), every conversion start arms a new frame. The first tick after the start gives sync, and the next tick gives the most significant bit.
- R9: While no read window is open, sync and data are 0. When a window closes, both are 0 from the next system clock.
- R10: In read-after mode, a read window requested while `busy_n_o` is 0 produces no sync and no data until the busy flag returns to 1.
- R11: Between ticks, data and sync hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = read after conversion, 1 = read during conversion |
| cs_n_i | input | 1 | Active-low chip-select |
| rc_i | input | 1 | Read (high) / convert (low) |
| dclk_tick_i | input | 1 | One-cycle pulse per rising data-clock edge |
| tag_i | input | 1 | Chain input forwarded after the result |
| conv_word_i | input | W | Word from the stub converter core |
| busy_n_o | output | 1 | Low while a conversion runs |
| sync_o | output | 1 | Frame marker, one tick long |
| data_o | output | 1 | Serial result, then chain bits |

## Verification
Suppose the shift register loads at the wrong tick or shifts in the wrong direction. Then the first wrong bit shows on data within W+1 ticks of the sync pulse, and a sweep of walking-one words places it at an exact position. If the chain stage is wrong, the error shows at tick W+2, where the tag bit from tick 2 should reappear. A faulty busy counter or result latch shows in one of two ways: the count of clocks with busy low is wrong, or a read-during frame carries the new word instead of the old one. A state machine that fails to close the frame shows as nonzero data one clock after chip-select rises.

// File: rtl/adcsr_pkg.sv
package adcsr_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SYNC  = 2'd1,
    FR_SHIFT = 2'd2
  } frame_st_e;

  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/adcsr_ctrl_sync.sv
module adcsr_ctrl_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic rc_i,
  output logic conv_start_o,
  output logic read_req_o
);
  // one capture stage plus one history stage per control line
  logic cs_q, cs_p, rc_q, rc_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      cs_p <= 1'b1;
      rc_q <= 1'b1;
      rc_p <= 1'b1;
    end else begin
      cs_q <= cs_n_i;
      cs_p <= cs_q;
      rc_q <= rc_i;
      rc_p <= rc_q;
    end
  end

  logic cs_fall, rc_fall;
  assign cs_fall = cs_p & ~cs_q;
  assign rc_fall = rc_p & ~rc_q;

  assign conv_start_o = (cs_fall & ~rc_q) | (rc_fall & ~cs_q);
  assign read_req_o   = ~cs_q & rc_q;
endmodule

// File: rtl/adcsr_conv_model.sv
module adcsr_conv_model #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_start_i,
  input  logic [W-1:0] conv_word_i,
  output logic         busy_n_o,
  output logic [W-1:0] result_o
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n_o <= 1'b1;
      cnt      <= '0;
      result_o <= '0;
    end else if (busy_n_o) begin
      if (conv_start_i) begin
        busy_n_o <= 1'b0;
        cnt      <= LAST;
      end
    end else if (cnt == '0) begin
      busy_n_o <= 1'b1;
      result_o <= conv_word_i;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/adcsr_frame.sv
module adcsr_frame
  import adcsr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         win_i,
  input  logic         restart_i,
  input  logic         tag_i,
  input  logic [W-1:0] result_i,
  output logic         sync_o,
  output logic         data_o
);
  frame_st_e    st;
  logic [W-1:0] sr;

  // After the load, the chain bits enter at the bottom and leave W ticks later.
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= FR_IDLE;
      sync_o <= 1'b0;
      data_o <= 1'b0;
      sr     <= '0;
    end else if (!win_i || restart_i) begin
      st     <= FR_IDLE;
      sync_o <= 1'b0;
      data_o <= 1'b0;
    end else if (tick_i) begin
      case (st)
        FR_IDLE: begin
          sync_o <= 1'b1;
          data_o <= 1'b0;
          st     <= FR_SYNC;
        end
        FR_SYNC: begin
          sync_o <= 1'b0;
          data_o <= result_i[W-1];
          sr     <= {result_i[W-2:0], tag_i};
          st     <= FR_SHIFT;
        end
        default: begin
          sync_o <= 1'b0;
          data_o <= sr[W-1];
          sr     <= {sr[W-2:0], tag_i};
        end
      endcase
    end
  end
endmodule

// File: rtl/adcsr_serial_out.sv
module adcsr_serial_out
  import adcsr_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_i,
  input  logic         cs_n_i,
  input  logic         rc_i,
  input  logic         dclk_tick_i,
  input  logic         tag_i,
  input  logic [W-1:0] conv_word_i,
  output logic         busy_n_o,
  output logic         sync_o,
  output logic         data_o
);
  logic         conv_start, read_req, during_armed, read_win, restart;
  logic [W-1:0] result_q;

  adcsr_ctrl_sync u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cs_n_i       (cs_n_i),
    .rc_i         (rc_i),
    .conv_start_o (conv_start),
    .read_req_o   (read_req)
  );

  adcsr_conv_model #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk          (clk),
    .rst          (rst),
    .conv_start_i (conv_start),
    .conv_word_i  (conv_word_i),
    .busy_n_o     (busy_n_o),
    .result_o     (result_q)
  );

  // read-during mode: each start re-arms a frame that runs until the next start
  always_ff @(posedge clk) begin
    if (rst || rd_mode_e'(mode_i) != RD_DURING) during_armed <= 1'b0;
    else if (conv_start)                        during_armed <= 1'b1;
  end

  assign restart  = conv_start & (rd_mode_e'(mode_i) == RD_DURING);
  assign read_win = (rd_mode_e'(mode_i) == RD_DURING) ? during_armed
                                                      : (read_req & busy_n_o);

  adcsr_frame #(.W(W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (dclk_tick_i),
    .win_i     (read_win),
    .restart_i (restart),
    .tag_i     (tag_i),
    .result_i  (result_q),
    .sync_o    (sync_o),
    .data_o    (data_o)
  );
endmodule

// File: rtl/adcsr_checker.sv
module adcsr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_i,
  input logic         read_win,
  input logic         restart,
  input logic         conv_start,
  input logic         busy_n_o,
  input logic [W-1:0] result_q,
  input logic         sync_o,
  input logic         data_o
);
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n_o) |-> $past(conv_start));

  a_r4_result_on_busy_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> $rose(busy_n_o));

  a_r5_sync_from_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(tick_i));

  a_r5_sync_one_tick: assert property (@(posedge clk) disable iff (rst)
    (sync_o && tick_i) |=> !sync_o);

  a_r9_closed_quiet: assert property (@(posedge clk) disable iff (rst)
    !read_win |=> (!sync_o && !data_o));

  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> ($past(tick_i) || !$past(read_win) || $past(restart)));
endmodule

bind adcsr_serial_out adcsr_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (dclk_tick_i),
  .read_win   (read_win),
  .restart    (restart),
  .conv_start (conv_start),
  .busy_n_o   (busy_n_o),
  .result_q   (result_q),
  .sync_o     (sync_o),
  .data_o     (data_o)
);

// File: tb/sim_adcsr_serial_out.sv
module sim_adcsr_serial_out;
  localparam int W = 16;
  localparam int C = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic mode = 1'b0, cs_n = 1'b1, rc = 1'b1, tk = 1'b0, tag = 1'b0;
  logic [W-1:0] word = '0;
  logic busy_n, sync, data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adcsr_serial_out #(.W(W), .CONV_CYCLES(C)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .cs_n_i(cs_n), .rc_i(rc),
    .dclk_tick_i(tk), .tag_i(tag), .conv_word_i(word),
    .busy_n_o(busy_n), .sync_o(sync), .data_o(data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic tagpat(input int k);
    return ((k * 5 + 1) % 3) == 0;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk) tk = 1'b1;
    @(negedge clk) tk = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 1000 && !busy_n; g++) @(negedge clk);
  endtask

  // conversion started by chip-select falling with read/convert low; busy cycles counted
  task automatic start_measure(input logic retrigger);
    int cnt = 0;
    @(negedge clk) rc = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 1; i <= C + 8; i++) begin
      @(negedge clk);
      if (i == 2) begin cs_n = 1'b1; if (!retrigger) rc = 1'b1; end
      if (retrigger && i == 6) cs_n = 1'b0;
      if (retrigger && i == 8) begin cs_n = 1'b1; rc = 1'b1; end
      if (!busy_n) cnt++;
    end
    chk(retrigger ? "R3 busy length with retrigger" : "R2 busy length", cnt, C);
  endtask

  // ticks of one frame; k=0 is the sync tick
  task automatic run_frame(input logic [W-1:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      tag = tagpat(k);
      tick_once();
      if (k == 0) begin
        chk("R5 sync high", sync, 1);
        chk("R5 data low at sync", data, 0);
      end else begin
        chk("R5 sync one tick", sync, 0);
        if (k <= W) chk("R6 result bit", data, w[W-k]);
        else        chk("R7 chain bit", data, tagpat(k - W));
      end
      if (k == 1 || k == W + 1) begin
        wait_clk(2);
        chk("R11 data holds", data, (k == 1) ? w[W-1] : tagpat(1));
      end
    end
  endtask

  task automatic read_after(input logic [W-1:0] w);
    word = w;
    start_measure(1'b0);
    chk("R4 busy done", busy_n, 1);
    @(negedge clk) cs_n = 1'b0;
    wait_clk(2);
    run_frame(w, W + 4);
    @(negedge clk) cs_n = 1'b1;
    wait_clk(2);
    chk("R9 sync low after close", sync, 0);
    chk("R9 data low after close", data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 sync reset", sync, 0);
    chk("R1 data reset", data, 0);
    chk("R1 busy reset", busy_n, 1);

    // R9: ticks with no read window produce nothing
    for (int i = 0; i < 3; i++) begin
      tick_once();
      chk("R9 no window", {sync, data}, 0);
    end

    // R3: second start during busy ignored
    word = 16'h1234;
    start_measure(1'b1);

    // R5 R6 R7 sweep in read-after mode
    for (int b = 0; b < W; b++) read_after(16'(1) << b);
    read_after(16'hFFFF);
    read_after(16'h0000);
    read_after(16'hA5C3);

    // R10: read requested while busy
    word = 16'h6E91;
    @(negedge clk) rc = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    wait_clk(2);
    rc = 1'b1;
    wait_clk(1);
    for (int i = 0; i < 3; i++) begin
      tick_once();
      chk("R10 no frame while busy", {sync, data}, 0);
    end
    wait_idle();
    wait_clk(2);
    run_frame(16'h6E91, W + 2);
    @(negedge clk) cs_n = 1'b1;
    wait_clk(2);
    chk("R9 closed after R10 frame", {sync, data}, 0);

    // R8 R4: read-during mode, chip-select held low, read/convert starts
    mode = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    word = 16'hC0DE;
    @(negedge clk) rc = 1'b0;
    wait_clk(2);
    rc = 1'b1;
    wait_idle();
    chk("R2 start by rc fall", busy_n, 1);
    for (int r = 0; r < 3; r++) begin
      logic [W-1:0] prev;
      prev = word;
      word = (r == 0) ? 16'h3B07 : (r == 1) ? 16'h8001 : 16'h5AA5;
      @(negedge clk) rc = 1'b0;
      wait_clk(3);
      rc = 1'b1;
      chk("R8 busy during read", busy_n, 0);
      run_frame(prev, W + 2);
      chk("R4 read finished before busy end", busy_n, 0);
      wait_idle();
    end
    @(negedge clk) begin mode = 1'b0; cs_n = 1'b1; end
    wait_clk(2);
    chk("R9 quiet after mode change", {sync, data}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule